// File: doc/BRIEF.md
# Cartridge Bank Mapper with Serial Page Select

This block sits between an 8-bit CPU's cartridge address space and a byte-wide parallel flash of 2 MB. The CPU sees a 32 KB region through a 15-bit address. That region has two halves:

- **Lower half (switchable).** Offset bit 14 is low. It shows one 16 KB page of flash, and a bank register chooses which page.
- **Upper half (fixed).** Offset bit 14 is high. It always shows the last 16 KB page of flash, so the reset and interrupt vectors can always be reached.

The 21-bit flash address is built in two parts:

- The 14 low offset bits pass straight through.
- The 7 page bits come either from the active bank register or are forced to all ones.

Software sets the page through three general-purpose pins: a serial clock, a serial data line and a latch. Page bits are shifted into a staging register. The staged value moves to the active bank register only when the latch goes high. Because of this, a half-shifted page number never reaches the flash address. The serial pins are sampled by the system clock, and edges on them are detected against the previous sample.

The block also drives the flash chip enable from the cartridge select, and the flash output enable from CPU read cycles inside the cartridge.

Top module: `cart_bank_mapper`

## Requirements
- R1: Flash address bits 13:0 always equal CPU offset bits 13:0.
- R2: When CPU offset bit 14 is 0, flash address bits 20:14 equal the active bank register.
- R3: When CPU offset bit 14 is 1, flash address bits 20:14 are all ones (page 127), whatever the bank register holds.
- R4: After a synchronous active-high reset, the active bank register and the staging register are zero.
- R5: On each detected rising edge of the serial clock, the serial data bit enters the staging register at bit 0, and the older bits move up one place. A page is therefore sent MSB first. If more than 7 bits are shifted, only the last 7 remain.
- R6: Shifting bits without a rising edge of the latch leaves the flash address unchanged.
- R7: Only a rising edge of the latch copies the staging register into the active bank register. Holding the latch high while further bits are shifted loads nothing more.
- R8: `flash_ce_n` is low exactly when `cart_sel` is high.
- R9: `flash_oe_n` is low exactly when `cart_sel` and `cpu_rd` are both high.
- R10: A serial clock that stays high for many system clocks shifts exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial page clock; its rising edge shifts one bit |
| ser_dat | input | 1 | Serial page data, MSB first |
| ser_lat | input | 1 | Latch; its rising edge loads the staged page |
| cpu_addr | input | 15 | CPU offset within the 32 KB cartridge region |
| cart_sel | input | 1 | Cartridge region selected |
| cpu_rd | input | 1 | CPU read cycle |
| flash_addr | output | 21 | Byte address to flash |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |

## Verification
The bench loads pages whose first and last bits differ:

- **Bit order.** A shifter that ran LSB first would map those pages to their bit-reversed page.
- **Overlong streams.** It shifts more than 7 bits. A design that kept the oldest bits instead of the newest would select the wrong page.
- **Shifting without a latch.** It probes the mapping between shifting and latching, which shows a design that exposes staged bits early.
- **Latch held high.** It keeps the latch high while shifting more bits, which catches a level-triggered load.
- **Long serial clock.** It holds the serial clock high for many cycles, which catches a shifter that acts on level rather than edge.
- **Fixed window.** It reads the upper half while a non-top page is active, so a design that forgot to force the page bits to all ones would fail.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    localparam int CPU_AW   = 15;
    localparam int WIN_W    = 14;
    localparam int PAGE_W   = 7;
    localparam int FLASH_AW = WIN_W + PAGE_W;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        page_t             page;
        logic [WIN_W-1:0]  offset;
    } flash_addr_t;

    typedef enum logic {
        WIN_SWITCHED = 1'b0,
        WIN_FIXED    = 1'b1
    } win_sel_e;

    function automatic win_sel_e decode_window(input logic [CPU_AW-1:0] a);
        return a[CPU_AW-1] ? WIN_FIXED : WIN_SWITCHED;
    endfunction
endpackage

// File: rtl/cart_bank_shifter.sv
module cart_bank_shifter
    import cart_map_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_clk,
    input  logic          ser_dat,
    input  logic          ser_lat,
    output logic [PW-1:0] bank
);
    logic          sclk_q, lat_q;
    logic          sclk_rise, lat_rise;
    logic [PW-1:0] stage_q, bank_q;

    assign sclk_rise = ser_clk & ~sclk_q;
    assign lat_rise  = ser_lat & ~lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            lat_q   <= 1'b0;
            stage_q <= '0;
            bank_q  <= '0;
        end else begin
            sclk_q <= ser_clk;
            lat_q  <= ser_lat;
            if (sclk_rise) stage_q <= {stage_q[PW-2:0], ser_dat};
            if (lat_rise)  bank_q  <= stage_q;
        end
    end

    assign bank = bank_q;

    p_reset_clear_r4: assert property (@(posedge clk) rst |=> (bank_q == '0 && stage_q == '0));
    p_shift_in_r5: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> stage_q[0] == $past(ser_dat));
    p_hold_no_edge_r10: assert property (@(posedge clk) disable iff (rst)
        !sclk_rise |=> $stable(stage_q));
    p_hold_no_latch_r6: assert property (@(posedge clk) disable iff (rst)
        !lat_rise |=> $stable(bank_q));
    p_load_on_latch_r7: assert property (@(posedge clk) disable iff (rst)
        lat_rise |=> bank_q == $past(stage_q));
endmodule

// File: rtl/cart_addr_compose.sv
module cart_addr_compose
    import cart_map_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int WW = WIN_W,
    parameter int PW = PAGE_W
) (
    input  logic [AW-1:0]    cpu_addr,
    input  logic [PW-1:0]    bank,
    output logic [WW+PW-1:0] flash_addr
);
    win_sel_e        win;
    logic [PW-1:0]   page;
    flash_addr_t     fa;

    assign win = decode_window(cpu_addr);

    for (genvar i = 0; i < PW; i++) begin : g_page_bit
        assign page[i] = (win == WIN_FIXED) ? 1'b1 : bank[i];
    end

    assign fa.page   = page;
    assign fa.offset = cpu_addr[WW-1:0];
    assign flash_addr = fa;
endmodule

// File: rtl/cart_strobe_gen.sv
module cart_strobe_gen (
    input  logic cart_sel,
    input  logic cpu_rd,
    output logic ce_n,
    output logic oe_n
);
    assign ce_n = ~cart_sel;
    assign oe_n = ~(cart_sel & cpu_rd);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk,
    input  logic                ser_dat,
    input  logic                ser_lat,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic                cart_sel,
    input  logic                cpu_rd,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic                flash_ce_n,
    output logic                flash_oe_n
);
    page_t bank;

    cart_bank_shifter #(.PW(PAGE_W)) u_shift (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .bank(bank)
    );

    cart_addr_compose #(.AW(CPU_AW), .WW(WIN_W), .PW(PAGE_W)) u_comp (
        .cpu_addr(cpu_addr), .bank(bank), .flash_addr(flash_addr)
    );

    cart_strobe_gen u_strb (
        .cart_sel(cart_sel), .cpu_rd(cpu_rd),
        .ce_n(flash_ce_n), .oe_n(flash_oe_n)
    );

    p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
        flash_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]);
    p_switched_page_r2: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[CPU_AW-1] |-> flash_addr[FLASH_AW-1:WIN_W] == bank);
    p_fixed_top_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[CPU_AW-1] |-> &flash_addr[FLASH_AW-1:WIN_W]);
    p_chip_enable_r8: assert property (@(posedge clk) disable iff (rst)
        flash_ce_n == !cart_sel);
    p_out_enable_r9: assert property (@(posedge clk) disable iff (rst)
        flash_oe_n == !(cart_sel && cpu_rd));
endmodule

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic        cart_sel = 1'b0, cpu_rd = 1'b0;
    logic [20:0] flash_addr;
    logic        flash_ce_n, flash_oe_n;

    int n_chk = 0, n_bad = 0;
    logic [6:0] exp_stage = '0, exp_bank = '0;
    bit done = 0;

    always #2 clk = ~clk;

    cart_bank_mapper u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .cpu_addr(cpu_addr), .cart_sel(cart_sel),
        .cpu_rd(cpu_rd), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n)
    );

    function automatic logic [20:0] model_addr(input logic [14:0] a, input logic [6:0] pg);
        return {(a[14] ? 7'h7F : pg), a[13:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int hold);
        ser_dat = b; ser_clk = 1'b0; wait_cyc(2);
        ser_clk = 1'b1; wait_cyc(hold);
        exp_stage = {exp_stage[5:0], b};
        ser_clk = 1'b0; wait_cyc(1);
    endtask

    task automatic send_bits(input logic [15:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) send_bit(v[i], 2);
    endtask

    task automatic latch(input bit drop);
        ser_lat = 1'b1; wait_cyc(2);
        exp_bank = exp_stage;
        if (drop) begin ser_lat = 1'b0; wait_cyc(1); end
    endtask

    task automatic probe(input logic [14:0] a, input string req);
        cpu_addr = a; #1;
        check(flash_addr == model_addr(a, exp_bank), req, 32'(flash_addr), 32'(model_addr(a, exp_bank)));
        wait_cyc(1);
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        n_bad++;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R4: reset state, page zero visible in lower half
        probe(15'h1234, "R4");
        probe(15'h3FFF, "R2");
        // R3: upper half pinned to top page
        probe(15'h4000, "R3");
        probe(15'h7FFF, "R3");
        // R5: MSB first, page 0x41 (reversal would give 0x41 too, so use 0x03)
        send_bits(16'h03, 7); latch(1);
        probe(15'h0000, "R5");
        send_bits(16'h40, 7); latch(1);
        probe(15'h0ABC, "R5");
        // R5: overlong stream keeps last 7 bits
        send_bits(16'hA5C3, 16); latch(1);
        probe(15'h2222, "R5");
        // R3: fixed window while non-top page active
        probe(15'h5555, "R3");
        // R6: shift without latch leaves mapping
        send_bits(16'h15, 7);
        probe(15'h1111, "R6");
        // R7: latch held high, further shifts do not load
        latch(0);
        probe(15'h0F0F, "R7");
        send_bits(16'h6A, 7);
        probe(15'h0F0F, "R7");
        ser_lat = 1'b0; wait_cyc(1);
        latch(1);
        probe(15'h0F0F, "R7");
        // R10: long-held serial clock shifts once
        send_bit(1'b1, 40);
        for (int i = 0; i < 6; i++) send_bit(1'b0, 2);
        latch(1);
        probe(15'h0001, "R10");
        // R8 / R9: strobes
        for (int k = 0; k < 4; k++) begin
            cart_sel = k[1]; cpu_rd = k[0]; #1;
            check(flash_ce_n == !cart_sel, "R8", 32'(flash_ce_n), 32'(!cart_sel));
            check(flash_oe_n == !(cart_sel && cpu_rd), "R9", 32'(flash_oe_n), 32'(!(cart_sel && cpu_rd)));
            wait_cyc(1);
        end
        // R1 R2 R3: random pages and addresses
        for (int it = 0; it < 150; it++) begin
            logic [6:0] pg;
            pg = 7'($urandom);
            send_bits({9'b0, pg}, 7); latch(1);
            for (int j = 0; j < 4; j++) begin
                logic [14:0] a;
                a = 15'($urandom);
                cpu_addr = a; #1;
                check(flash_addr[13:0] == a[13:0], "R1", 32'(flash_addr[13:0]), 32'(a[13:0]));
                check(flash_addr == model_addr(a, pg), a[14] ? "R3" : "R2",
                      32'(flash_addr), 32'(model_addr(a, pg)));
                wait_cyc(1);
            end
        end
        // R4: reset again clears active page
        rst = 1'b1; wait_cyc(2); rst = 1'b0;
        exp_bank = '0; exp_stage = '0;
        wait_cyc(1);
        probe(15'h3ABC, "R4");
        latch(1);
        probe(15'h3ABC, "R4");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule